// File: doc/BRIEF.md
# Packed Interleave and Saturating Pack Unit

This unit reorders or narrows the contents of two 128-bit operand vectors. In interleave mode it takes one 64-bit half, upper or lower, from each operand. It then builds the result by alternating elements of the two operands. The element width can be 8, 16, 32 or 64 bits. In pack mode it treats each operand as a vector of signed elements and halves their width. Values that do not fit the narrower type are clamped to its signed or unsigned range. The narrowed first operand forms the lower half of the result and the narrowed second operand forms the upper half.

A request is presented with a single-cycle `start` pulse together with both operands and the control fields. The result is registered. It appears one clock later, with `resultValid` high for exactly that cycle, and it stays unchanged until the next request.

Top module: `pack_unpack_unit`

## Requirements
- R1: While `rstN` is low, `resultValid` is 0 and `result` is all zeros.
- R2: `resultValid` is high in exactly the cycle after a cycle in which `start` was high, and low otherwise.
- R3: When `start` is low, `result` keeps its previous value, whatever the other inputs do.
- R4: Interleave with the lower half (`opMode`=0, `highHalf`=0) at element width W = 8<<`elemSize` (0=8, 1=16, 2=32, 3=64 bits). Result element 2i is element i of `srcA[63:0]`, and result element 2i+1 is element i of `srcB[63:0]`. Element i occupies bits [i*W +: W].
- R5: Interleave with the upper half (`highHalf`=1) follows the same rule as R4, using `srcA[127:64]` and `srcB[127:64]`.
- R6: Pack with 16-bit sources (`opMode`=1, `elemSize`=1) and `signedSat`=1. Each signed 16-bit element is clamped to -128..127 and kept as its low 8 bits. Source element i of `srcA` goes to result byte i, and source element i of `srcB` goes to result byte 8+i.
- R7: Pack with 16-bit sources and `signedSat`=0. Each signed 16-bit element is clamped to 0..255, with the same placement as R6.
- R8: Pack with 32-bit sources (`elemSize`=2) and `signedSat`=1. Each signed 32-bit element is clamped to -32768..32767. Element i of `srcA` goes to result halfword i, and element i of `srcB` goes to result halfword 4+i.
- R9: Pack with 32-bit sources and `signedSat`=0. Each signed 32-bit element is clamped to 0..65535, with the same placement as R8.
- R10: Pack with `elemSize` 0 or 3, which are unsupported source widths, yields an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, one cycle per operation |
| srcA | input | 128 | First operand |
| srcB | input | 128 | Second operand |
| opMode | input | 1 | 0 = interleave, 1 = pack |
| highHalf | input | 1 | Interleave: 1 = upper 64 bits, 0 = lower 64 bits |
| elemSize | input | 2 | Element width code: 0=8, 1=16, 2=32, 3=64 bits (source width in pack mode) |
| signedSat | input | 1 | Pack: 1 = signed clamp, 0 = unsigned clamp |
| result | output | 128 | Registered result |
| resultValid | output | 1 | High for one cycle when `result` holds a new value |

## Verification
Some checks run on every cycle. These cover the strobe timing (the valid flag tracks `start` with a one-cycle delay and is low in reset), the holding of the result register between requests, the 64-bit lower-half interleave, and the all-zero output for unsupported pack widths. The element placement at the three narrower interleave widths and the clamping at every saturation boundary (exact limits, one past them, negative values under unsigned clamping) depend on operand values. These are shown only by the bench's directed and random scenarios, which are compared against the behavioural model on every clock.

// File: rtl/pku_pkg.sv
package pku_pkg;
  localparam int SIZE_W = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } elemSize_e;

  typedef struct packed {
    logic            load;
    logic            isPack;
    logic            hiHalf;
    logic [SIZE_W-1:0] sizeSel;
    logic            sgnSat;
  } pkuCtrl_t;
endpackage

// File: rtl/pku_ctrl.sv
module pku_ctrl
  import pku_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opMode,
  input  logic              highHalf,
  input  logic [SIZE_W-1:0] elemSize,
  input  logic              signedSat,
  output pkuCtrl_t          ctrl,
  output logic              resultValid
);
  always_comb begin
    ctrl.load    = start;
    ctrl.isPack  = opMode;
    ctrl.hiHalf  = highHalf;
    ctrl.sizeSel = elemSize;
    ctrl.sgnSat  = signedSat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= start;
  end

  // R1: reset clears the strobe
  assert_reset_valid_R1: assert property (@(posedge clk) !rstN |=> !resultValid);
  // R2: strobe follows request by one cycle
  assert_valid_follows_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> resultValid);
  assert_valid_only_after_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !resultValid);
endmodule

// File: rtl/pku_sat.sv
module pku_sat #(
  parameter int IN_W = 16
) (
  input  logic [IN_W-1:0]   din,
  input  logic              sgnSat,
  output logic [IN_W/2-1:0] dout
);
  localparam int OUT_W = IN_W / 2;

  logic isNeg;
  logic fitsSigned;
  logic fitsUnsigned;

  always_comb begin
    isNeg        = din[IN_W-1];
    fitsSigned   = (din[IN_W-1:OUT_W-1] == '0) || (din[IN_W-1:OUT_W-1] == '1);
    fitsUnsigned = (din[IN_W-1:OUT_W] == '0);
    if (sgnSat) begin
      if (fitsSigned)  dout = din[OUT_W-1:0];
      else if (isNeg)  dout = {1'b1, {(OUT_W-1){1'b0}}};
      else             dout = {1'b0, {(OUT_W-1){1'b1}}};
    end else begin
      if (isNeg)             dout = '0;
      else if (fitsUnsigned) dout = din[OUT_W-1:0];
      else                   dout = '1;
    end
  end
endmodule

// File: rtl/pku_datapath.sv
module pku_datapath
  import pku_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  pkuCtrl_t          ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W    = DATA_W / 2;
  localparam int NUM_SIZES = 4;
  localparam int NUM_PACK  = 2;

  logic [HALF_W-1:0] halfA;
  logic [HALF_W-1:0] halfB;
  logic [DATA_W-1:0] ilvRes  [NUM_SIZES];
  logic [DATA_W-1:0] packRes [NUM_PACK];
  logic [DATA_W-1:0] nextRes;

  assign halfA = ctrl.hiHalf ? srcA[HALF_W +: HALF_W] : srcA[0 +: HALF_W];
  assign halfB = ctrl.hiHalf ? srcB[HALF_W +: HALF_W] : srcB[0 +: HALF_W];

  // interleave networks, one per element width
  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_ilv
    localparam int EW = 8 << s;
    localparam int NE = HALF_W / EW;
    for (genvar i = 0; i < NE; i++) begin : g_elem
      assign ilvRes[s][(2*i)*EW   +: EW] = halfA[i*EW +: EW];
      assign ilvRes[s][(2*i+1)*EW +: EW] = halfB[i*EW +: EW];
    end
  end

  // narrowing networks: p=0 -> 16-bit sources, p=1 -> 32-bit sources
  for (genvar p = 0; p < NUM_PACK; p++) begin : g_pack
    localparam int SW = 16 << p;
    localparam int DW = SW / 2;
    localparam int NS = DATA_W / SW;
    for (genvar i = 0; i < NS; i++) begin : g_elem
      pku_sat #(.IN_W(SW)) u_satA (
        .din   (srcA[i*SW +: SW]),
        .sgnSat(ctrl.sgnSat),
        .dout  (packRes[p][i*DW +: DW])
      );
      pku_sat #(.IN_W(SW)) u_satB (
        .din   (srcB[i*SW +: SW]),
        .sgnSat(ctrl.sgnSat),
        .dout  (packRes[p][(NS+i)*DW +: DW])
      );
    end
  end

  always_comb begin
    nextRes = '0;
    if (!ctrl.isPack) begin
      nextRes = ilvRes[ctrl.sizeSel];
    end else begin
      case (ctrl.sizeSel)
        SZ_16:   nextRes = packRes[0];
        SZ_32:   nextRes = packRes[1];
        default: nextRes = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          result <= '0;
    else if (ctrl.load) result <= nextRes;
  end

  // R3: register holds between requests
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(result));
  // R4: 64-bit lower-half interleave places A then B
  assert_qword_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.isPack && !ctrl.hiHalf && ctrl.sizeSel == SZ_64)
    |=> result == {$past(srcB[0 +: HALF_W]), $past(srcA[0 +: HALF_W])});
  // R10: unsupported pack widths give zero
  assert_bad_pack_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.isPack && (ctrl.sizeSel == SZ_8 || ctrl.sizeSel == SZ_64))
    |=> result == '0);
endmodule

// File: rtl/pack_unpack_unit.sv
module pack_unpack_unit
  import pku_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic              opMode,
  input  logic              highHalf,
  input  logic [1:0]        elemSize,
  input  logic              signedSat,
  output logic [DATA_W-1:0] result,
  output logic              resultValid
);
  pkuCtrl_t ctrl;

  pku_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .opMode     (opMode),
    .highHalf   (highHalf),
    .elemSize   (elemSize),
    .signedSat  (signedSat),
    .ctrl       (ctrl),
    .resultValid(resultValid)
  );

  pku_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .srcA  (srcA),
    .srcB  (srcB),
    .result(result)
  );

  // R1: result cleared by reset
  assert_reset_result_R1: assert property (@(posedge clk) !rstN |=> result == '0);
endmodule

// File: tb/pack_unpack_unit_bench.sv
module pack_unpack_unit_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [127:0] srcA = '0;
  logic [127:0] srcB = '0;
  logic         opMode = 1'b0;
  logic         highHalf = 1'b0;
  logic [1:0]   elemSize = 2'd0;
  logic         signedSat = 1'b0;
  logic [127:0] result;
  logic         resultValid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  string curReq = "R3";

  logic [127:0] expRes = '0;
  logic         expValid = 1'b0;
  string        expTag = "R1";
  bit           started = 1'b0;

  always #2 clk = ~clk;

  pack_unpack_unit u_pack_unpack_unit (
    .clk(clk), .rstN(rstN), .start(start), .srcA(srcA), .srcB(srcB),
    .opMode(opMode), .highHalf(highHalf), .elemSize(elemSize),
    .signedSat(signedSat), .result(result), .resultValid(resultValid)
  );

  function automatic longint clampVal(longint v, int dw, bit sgn);
    longint lo, hi;
    if (sgn) begin lo = -(longint'(1) << (dw-1)); hi = (longint'(1) << (dw-1)) - 1; end
    else     begin lo = 0; hi = (longint'(1) << dw) - 1; end
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic longint signedField(logic [127:0] x, int pos, int w);
    longint v = 0;
    for (int k = 0; k < w; k++) if (x[pos+k]) v += longint'(1) << k;
    if (x[pos+w-1]) v -= longint'(1) << w;
    return v;
  endfunction

  function automatic logic [127:0] refOut(logic [127:0] a, logic [127:0] b,
                                          bit isPack, bit hi, int sz, bit sgn);
    logic [127:0] r = '0;
    if (!isPack) begin
      int ew = 8 << sz;
      int base = hi ? 64 : 0;
      for (int i = 0; i < 64/ew; i++)
        for (int k = 0; k < ew; k++) begin
          r[2*i*ew + k]     = a[base + i*ew + k];
          r[(2*i+1)*ew + k] = b[base + i*ew + k];
        end
    end else if (sz == 1 || sz == 2) begin
      int sw = 8 << sz;
      int dw = sw / 2;
      int ns = 128 / sw;
      for (int i = 0; i < ns; i++) begin
        longint va = clampVal(signedField(a, i*sw, sw), dw, sgn);
        longint vb = clampVal(signedField(b, i*sw, sw), dw, sgn);
        for (int k = 0; k < dw; k++) begin
          r[i*dw + k]      = va[k];
          r[(ns+i)*dw + k] = vb[k];
        end
      end
    end
    return r;
  endfunction

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    started <= 1'b1;
    if (!rstN) begin
      expValid <= 1'b0;
      expRes   <= '0;
      expTag   <= "R1";
    end else begin
      expValid <= start;
      if (start) begin
        expRes <= refOut(srcA, srcB, opMode, highHalf, int'(elemSize), signedSat);
        expTag <= curReq;
      end else begin
        expTag <= "R3";
      end
    end
  end

  // comparison on every falling edge
  always @(negedge clk) begin
    if (started && !finished) begin
      compared++;
      if (resultValid !== expValid) begin
        mismatched++;
        $display("FAIL %s valid: actual %b expected %b",
                 (expTag == "R1") ? "R1" : "R2", resultValid, expValid);
      end
      compared++;
      if (result !== expRes) begin
        mismatched++;
        $display("FAIL %s result: actual %h expected %h", expTag, result, expRes);
      end
    end
  end

  task automatic issue(input logic [127:0] a, input logic [127:0] b, input bit pk,
                       input bit hi, input logic [1:0] sz, input bit sgn, input string req);
    @(negedge clk);
    srcA = a; srcB = b; opMode = pk; highHalf = hi; elemSize = sz; signedSat = sgn;
    curReq = req; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    srcA = ~a; srcB = {b[63:0], b[127:64]}; opMode = ~pk; elemSize = sz + 2'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      srcA = {$urandom, $urandom, $urandom, $urandom};
      srcB = {$urandom, $urandom, $urandom, $urandom};
      opMode = $urandom; elemSize = $urandom; highHalf = $urandom;
    end
  endtask

  localparam logic [127:0] BYTES_A = 128'h0F0E0D0C0B0A09080706050403020100;
  localparam logic [127:0] BYTES_B = 128'h9F9E9D9C9B9A99989796959493929190;
  localparam logic [127:0] W16_A = {16'h0080, 16'hFF80, 16'h7FFF, 16'h8000,
                                    16'h00FF, 16'h0100, 16'hFFFF, 16'h0005};
  localparam logic [127:0] W16_B = {16'hFF7F, 16'h007F, 16'h0000, 16'hFFC0,
                                    16'h0101, 16'h00FE, 16'h8001, 16'h0042};
  localparam logic [127:0] W32_A = {32'h00008000, 32'hFFFF7FFF, 32'h7FFFFFFF, 32'h80000000};
  localparam logic [127:0] W32_B = {32'h0000FFFF, 32'h00010000, 32'hFFFFFFFF, 32'h00001234};

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(2);
    for (int s = 0; s < 4; s++) begin
      issue(BYTES_A, BYTES_B, 1'b0, 1'b0, 2'(s), 1'b0, "R4");
      issue(BYTES_A, BYTES_B, 1'b0, 1'b1, 2'(s), 1'b1, "R5");
    end
    issue(W16_A, W16_B, 1'b1, 1'b0, 2'd1, 1'b1, "R6");
    issue(W16_A, W16_B, 1'b1, 1'b1, 2'd1, 1'b0, "R7");
    issue(W32_A, W32_B, 1'b1, 1'b0, 2'd2, 1'b1, "R8");
    issue(W32_A, W32_B, 1'b1, 1'b1, 2'd2, 1'b0, "R9");
    issue(W32_A, W16_B, 1'b1, 1'b0, 2'd0, 1'b1, "R10");
    issue(W16_A, W32_B, 1'b1, 1'b0, 2'd3, 1'b0, "R10");
    idle(5); // R3: inputs churn without start
    // back-to-back requests
    @(negedge clk);
    srcA = W16_A; srcB = W32_B; opMode = 1'b1; elemSize = 2'd1; signedSat = 1'b1;
    curReq = "R6"; start = 1'b1;
    @(negedge clk);
    elemSize = 2'd2; signedSat = 1'b0; curReq = "R9";
    @(negedge clk);
    start = 1'b0;
    idle(2);
    for (int n = 0; n < 200; n++) begin
      logic [127:0] ra = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] rb = {$urandom, $urandom, $urandom, $urandom};
      bit pk = $urandom;
      bit hi = $urandom;
      bit sg = $urandom;
      logic [1:0] sz = 2'($urandom);
      string tag;
      if (!pk) tag = hi ? "R5" : "R4";
      else if (sz == 2'd1) tag = sg ? "R6" : "R7";
      else if (sz == 2'd2) tag = sg ? "R8" : "R9";
      else tag = "R10";
      issue(ra, rb, pk, hi, sz, sg, tag);
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    // R1: reset in the middle of activity
    issue(BYTES_A, BYTES_B, 1'b0, 1'b1, 2'd0, 1'b0, "R5");
    @(negedge clk);
    rstN = 1'b0; start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    rstN = 1'b1;
    idle(3);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule